// File: doc/BRIEF.md
# Split-Width Accumulator Datapath

This block is the register and routing slice of a small accumulator machine. It keeps a 16-bit accumulator, a 16-bit instruction register and a 12-bit data register, and moves memory words among them. Arithmetic happens elsewhere. The block hands the low 12 accumulator bits to the ALU as operand A and the data register to the ALU as operand B. It then takes a 12-bit ALU result back as one of three sources for the accumulator's low field.

The upper 4 accumulator bits never pass through the source multiplexer. On every accumulator write they come from the most recent memory read. A full 16-bit word, such as an instruction moved between two memory regions, can therefore be loaded from memory and stored back unchanged, even though the arithmetic path is only 12 bits wide. A small latch holds the top 4 bits of each memory read so that a later write can still use them. The instruction register supplies the 4-bit opcode field and a 12-bit immediate. The low 12 bits of the memory word are also offered to the program counter logic. The zero flag covers all 16 accumulator bits.

Top module: `split_acc_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, every register clears. After that edge `aluOperandA`, `aluOperandB`, `memWrData` and `opcode` read zero and `zeroFlag` reads 1.
- R2: With `accLoad`=1 and `accSel`=0, the accumulator low 12 bits take `aluResult` at the rising edge.
- R3: With `accLoad`=1 and `accSel`=1, the accumulator low 12 bits take instruction register bits [11:0] as they stood before the edge.
- R4: With `accLoad`=1 and `accSel`=2, the accumulator low 12 bits take `memRdData[11:0]`.
- R5: With `accLoad`=0, or with `accSel`=3 whatever `accLoad` is, all 16 accumulator bits keep their value.
- R6: On an accumulator write in a cycle where `memRdStrobe`=1, accumulator bits [15:12] take `memRdData[15:12]` of that same cycle, whatever the select.
- R7: On an accumulator write in a cycle where `memRdStrobe`=0, accumulator bits [15:12] take bits [15:12] of the last word presented with `memRdStrobe`=1. This value is zero if no such word has arrived since reset.
- R8: `aluOperandA` always equals accumulator bits [11:0`]`, and `memWrData` always equals all 16 accumulator bits.
- R9: With `irLoad`=1 the instruction register takes all 16 bits of `memRdData`. `opcode` shows its bits [15:12].
- R10: With `drLoad`=1 the data register takes `memRdData[11:0]`, and `aluOperandB` shows it.
- R11: `pcFromMem` equals `memRdData[11:0]` in the same cycle, with no register on the path.
- R12: `zeroFlag` is 1 exactly when all 16 accumulator bits are zero. It stays 0 when only the upper 4 bits are non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| memRdData | input | 16 | Word read from memory |
| memRdStrobe | input | 1 | Marks `memRdData` as a new read, captured by the upper-bit latch |
| aluResult | input | 12 | Result from the external ALU |
| accSel | input | 2 | Accumulator low-field source: 0 ALU, 1 immediate, 2 memory, 3 hold |
| accLoad | input | 1 | Accumulator write enable |
| irLoad | input | 1 | Instruction register write enable |
| drLoad | input | 1 | Data register write enable |
| aluOperandA | output | 12 | Accumulator low 12 bits |
| aluOperandB | output | 12 | Data register contents |
| memWrData | output | 16 | Full accumulator, used as store data |
| opcode | output | 4 | Instruction register bits [15:12] |
| pcFromMem | output | 12 | Memory word low 12 bits, offered to the program counter |
| zeroFlag | output | 1 | High when the whole accumulator is zero |

## Verification
The properties assume that `memRdData` is valid in every cycle where `memRdStrobe`, `irLoad`, `drLoad` or a memory-sourced accumulator write is active. They also assume that no enable is sampled as unknown once reset has ended. The bench drives every input from a defined value in every cycle. It sweeps every combination of select, the three enables and the strobe across several computed data words, so strobed and unstrobed writes interleave and the latched upper bits are reused. It never leaves a control input undriven after reset is released.

// File: rtl/sad_pkg.sv
package sad_pkg;

  typedef enum logic [1:0] {
    SRC_ALU  = 2'd0,
    SRC_IMM  = 2'd1,
    SRC_MEM  = 2'd2,
    SRC_HOLD = 2'd3
  } accSrcE;

  typedef struct packed {
    logic   accWr;
    accSrcE accSrc;
    logic   irWr;
    logic   drWr;
    logic   latchWr;
  } strobesT;

endpackage

// File: rtl/sad_reg.sv
module sad_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/sad_ctrl.sv
module sad_ctrl
  import sad_pkg::*;
(
  input  logic       accLoad,
  input  logic [1:0] accSel,
  input  logic       irLoad,
  input  logic       drLoad,
  input  logic       memRdStrobe,
  output strobesT    strobes
);
  accSrcE srcSel;

  always_comb begin
    srcSel          = accSrcE'(accSel);
    strobes.accSrc  = srcSel;
    // the hold code suppresses the write, so the upper field is preserved too
    strobes.accWr   = accLoad && (srcSel != SRC_HOLD);
    strobes.irWr    = irLoad;
    strobes.drWr    = drLoad;
    strobes.latchWr = memRdStrobe;
  end
endmodule

// File: rtl/sad_dpath.sv
module sad_dpath
  import sad_pkg::*;
#(
  parameter  int WORD_W = 16,
  parameter  int LOW_W  = 12,
  localparam int HI_W   = WORD_W - LOW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  strobesT           strobes,
  input  logic [WORD_W-1:0] memRdData,
  input  logic [LOW_W-1:0]  aluResult,
  output logic [WORD_W-1:0] accWord,
  output logic [WORD_W-1:0] irWord,
  output logic [LOW_W-1:0]  drWord,
  output logic [HI_W-1:0]   latchHi
);
  logic [LOW_W-1:0]  lowNext;
  logic [HI_W-1:0]   hiNext;
  logic [WORD_W-1:0] accNext;

  // low field: the only part that passes through the source multiplexer
  always_comb begin
    unique case (strobes.accSrc)
      SRC_ALU: lowNext = aluResult;
      SRC_IMM: lowNext = irWord[LOW_W-1:0];
      SRC_MEM: lowNext = memRdData[LOW_W-1:0];
      default: lowNext = accWord[LOW_W-1:0];
    endcase
  end

  // upper field: the newest memory word, forwarded when it arrives this cycle
  always_comb begin
    hiNext  = strobes.latchWr ? memRdData[WORD_W-1:LOW_W] : latchHi;
    accNext = {hiNext, lowNext};
  end

  sad_reg #(.W(WORD_W)) accReg_i (
    .clk(clk), .rst(rst), .en(strobes.accWr), .d(accNext), .q(accWord)
  );

  sad_reg #(.W(WORD_W)) irReg_i (
    .clk(clk), .rst(rst), .en(strobes.irWr), .d(memRdData), .q(irWord)
  );

  sad_reg #(.W(LOW_W)) drReg_i (
    .clk(clk), .rst(rst), .en(strobes.drWr), .d(memRdData[LOW_W-1:0]), .q(drWord)
  );

  sad_reg #(.W(HI_W)) latchReg_i (
    .clk(clk), .rst(rst), .en(strobes.latchWr), .d(memRdData[WORD_W-1:LOW_W]), .q(latchHi)
  );
endmodule

// File: rtl/split_acc_datapath.sv
module split_acc_datapath
  import sad_pkg::*;
#(
  parameter  int WORD_W = 16,
  parameter  int LOW_W  = 12,
  localparam int HI_W   = WORD_W - LOW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] memRdData,
  input  logic              memRdStrobe,
  input  logic [LOW_W-1:0]  aluResult,
  input  logic [1:0]        accSel,
  input  logic              accLoad,
  input  logic              irLoad,
  input  logic              drLoad,
  output logic [LOW_W-1:0]  aluOperandA,
  output logic [LOW_W-1:0]  aluOperandB,
  output logic [WORD_W-1:0] memWrData,
  output logic [HI_W-1:0]   opcode,
  output logic [LOW_W-1:0]  pcFromMem,
  output logic              zeroFlag
);
  strobesT           strobes;
  logic [WORD_W-1:0] accWord;
  logic [WORD_W-1:0] irWord;
  logic [LOW_W-1:0]  drWord;
  logic [HI_W-1:0]   latchHi;

  sad_ctrl ctrl_i (
    .accLoad(accLoad), .accSel(accSel), .irLoad(irLoad),
    .drLoad(drLoad), .memRdStrobe(memRdStrobe), .strobes(strobes)
  );

  sad_dpath #(.WORD_W(WORD_W), .LOW_W(LOW_W)) dpath_i (
    .clk(clk), .rst(rst), .strobes(strobes), .memRdData(memRdData),
    .aluResult(aluResult), .accWord(accWord), .irWord(irWord),
    .drWord(drWord), .latchHi(latchHi)
  );

  assign aluOperandA = accWord[LOW_W-1:0];
  assign aluOperandB = drWord;
  assign memWrData   = accWord;
  assign opcode      = irWord[WORD_W-1:LOW_W];
  assign pcFromMem   = memRdData[LOW_W-1:0];
  assign zeroFlag    = ~|accWord;
endmodule

// File: rtl/sad_chk.sv
module sad_chk #(
  parameter  int WORD_W = 16,
  parameter  int LOW_W  = 12,
  localparam int HI_W   = WORD_W - LOW_W
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] memRdData,
  input logic              memRdStrobe,
  input logic [LOW_W-1:0]  aluResult,
  input logic [1:0]        accSel,
  input logic              accLoad,
  input logic              irLoad,
  input logic              drLoad,
  input logic [LOW_W-1:0]  aluOperandA,
  input logic [LOW_W-1:0]  aluOperandB,
  input logic [WORD_W-1:0] memWrData,
  input logic [HI_W-1:0]   opcode,
  input logic              zeroFlag,
  input logic [LOW_W-1:0]  irImm,
  input logic [HI_W-1:0]   latchHi
);
  logic accWrite;
  assign accWrite = accLoad && (accSel != 2'd3);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (memWrData == '0 && aluOperandB == '0 && opcode == '0 && zeroFlag));

  // R2
  src_alu_chk: assert property (@(posedge clk) disable iff (rst)
    (accLoad && accSel == 2'd0) |=> aluOperandA == $past(aluResult));

  // R3
  src_imm_chk: assert property (@(posedge clk) disable iff (rst)
    (accLoad && accSel == 2'd1) |=> aluOperandA == $past(irImm));

  // R4
  src_mem_chk: assert property (@(posedge clk) disable iff (rst)
    (accLoad && accSel == 2'd2) |=> aluOperandA == $past(memRdData[LOW_W-1:0]));

  // R5
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !accWrite |=> $stable(memWrData));

  // R6
  hi_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (accWrite && memRdStrobe) |=> memWrData[WORD_W-1:LOW_W] == $past(memRdData[WORD_W-1:LOW_W]));

  // R7
  hi_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (accWrite && !memRdStrobe) |=> memWrData[WORD_W-1:LOW_W] == $past(latchHi));

  // R8
  operand_split_chk: assert property (@(posedge clk) disable iff (rst)
    aluOperandA == memWrData[LOW_W-1:0]);

  // R9
  ir_load_chk: assert property (@(posedge clk) disable iff (rst)
    irLoad |=> opcode == $past(memRdData[WORD_W-1:LOW_W]));

  // R10
  dr_load_chk: assert property (@(posedge clk) disable iff (rst)
    drLoad |=> aluOperandB == $past(memRdData[LOW_W-1:0]));

  // R12
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    zeroFlag == (memWrData == '0));
endmodule

bind split_acc_datapath sad_chk #(.WORD_W(WORD_W), .LOW_W(LOW_W)) chk_i (
  .clk(clk), .rst(rst), .memRdData(memRdData), .memRdStrobe(memRdStrobe),
  .aluResult(aluResult), .accSel(accSel), .accLoad(accLoad), .irLoad(irLoad),
  .drLoad(drLoad), .aluOperandA(aluOperandA), .aluOperandB(aluOperandB),
  .memWrData(memWrData), .opcode(opcode), .zeroFlag(zeroFlag),
  .irImm(irWord[LOW_W-1:0]), .latchHi(latchHi)
);

// File: tb/split_acc_datapath_tb.sv
`timescale 1ns/1ps
module split_acc_datapath_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] memRdData = '0;
  logic        memRdStrobe = 1'b0;
  logic [11:0] aluResult = '0;
  logic [1:0]  accSel = 2'd3;
  logic        accLoad = 1'b0;
  logic        irLoad = 1'b0;
  logic        drLoad = 1'b0;
  logic [11:0] aluOperandA, aluOperandB, pcFromMem;
  logic [15:0] memWrData;
  logic [3:0]  opcode;
  logic        zeroFlag;

  int errors = 0;
  int checks = 0;

  logic [15:0] mAcc = '0;
  logic [15:0] mIr = '0;
  logic [11:0] mDr = '0;
  logic [3:0]  mLatch = '0;

  always #2.5 clk = ~clk;

  split_acc_datapath dut_i (
    .clk(clk), .rst(rst), .memRdData(memRdData), .memRdStrobe(memRdStrobe),
    .aluResult(aluResult), .accSel(accSel), .accLoad(accLoad), .irLoad(irLoad),
    .drLoad(drLoad), .aluOperandA(aluOperandA), .aluOperandB(aluOperandB),
    .memWrData(memWrData), .opcode(opcode), .pcFromMem(pcFromMem),
    .zeroFlag(zeroFlag)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkState(input string lowTag, input string hiTag);
    chk(lowTag, {4'h0, aluOperandA}, {4'h0, mAcc[11:0]});
    chk({hiTag, " upper"}, {12'h0, memWrData[15:12]}, {12'h0, mAcc[15:12]});
    chk("R8 store", memWrData, mAcc);
    chk("R9 opcode", {12'h0, opcode}, {12'h0, mIr[15:12]});
    chk("R10 operandB", {4'h0, aluOperandB}, {4'h0, mDr});
    chk("R12 zero", {15'h0, zeroFlag}, {15'h0, (mAcc == 16'h0)});
  endtask

  // drive at a falling edge, register at the rising edge, check at the next falling edge
  task automatic step(input bit aL, input logic [1:0] s, input bit iL, input bit dL,
                      input bit st, input logic [15:0] m, input logic [11:0] a);
    logic [3:0]  hi;
    logic [11:0] lo;
    bit          wr;
    string       lowTag;
    string       hiTag;
    accLoad = aL; accSel = s; irLoad = iL; drLoad = dL;
    memRdStrobe = st; memRdData = m; aluResult = a;
    #1;
    chk("R11 pc", {4'h0, pcFromMem}, {4'h0, m[11:0]});
    wr = aL && (s != 2'd3);
    hi = st ? m[15:12] : mLatch;
    case (s)
      2'd0: begin lo = a;          lowTag = "R2 alu src";  end
      2'd1: begin lo = mIr[11:0];  lowTag = "R3 imm src";  end
      2'd2: begin lo = m[11:0];    lowTag = "R4 mem src";  end
      default: begin lo = mAcc[11:0]; lowTag = "R5 hold"; end
    endcase
    if (!wr) lowTag = "R5 hold";
    hiTag = !wr ? "R5 hold" : (st ? "R6 forward" : "R7 latched");
    @(posedge clk);
    if (wr) mAcc = {hi, lo};
    if (st) mLatch = m[15:12];
    if (iL) mIr = m;
    if (dL) mDr = m[11:0];
    @(negedge clk);
    checkState(lowTag, hiTag);
  endtask

  task automatic doReset();
    rst = 1'b1;
    accLoad = 1'b0; irLoad = 1'b0; drLoad = 1'b0; memRdStrobe = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    mAcc = '0; mIr = '0; mDr = '0; mLatch = '0;
    chk("R1 store", memWrData, 16'h0);
    chk("R1 operandA", {4'h0, aluOperandA}, 16'h0);
    chk("R1 operandB", {4'h0, aluOperandB}, 16'h0);
    chk("R1 opcode", {12'h0, opcode}, 16'h0);
    chk("R1 zero", {15'h0, zeroFlag}, 16'h1);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();

    // R7: write before any strobed read since reset takes zero upper bits
    step(1, 2'd0, 0, 0, 0, 16'hABCD, 12'h123);
    // R12: upper-only non-zero accumulator
    step(1, 2'd2, 0, 0, 1, 16'hF000, 12'h000);
    // R5: select 3 with load high keeps the whole word
    step(1, 2'd3, 0, 0, 1, 16'h1234, 12'hFFF);
    // R12: true zero
    step(1, 2'd2, 0, 0, 1, 16'h0000, 12'h000);

    // near-exhaustive sweep of controls over computed data words
    for (int k = 0; k < 8; k++) begin
      for (int s = 0; s < 4; s++) begin
        for (int c = 0; c < 16; c++) begin
          logic [15:0] m;
          logic [11:0] a;
          m = 16'(k * 40503 + s * 4099 + c * 2731 + 16'h5A3C);
          a = 12'(k * 1237 + s * 331 + c * 97);
          if (k == 0 && c == 5) begin m = 16'h0000; a = 12'h000; end
          if (k == 1 && c == 9) begin m = 16'h7000; a = 12'h000; end
          step(c[0], 2'(s), c[1], c[2], c[3], m, a);
        end
      end
    end

    // a full word copy: load with strobe, then store unchanged
    step(0, 2'd3, 1, 0, 1, 16'hC5A7, 12'h000);
    step(1, 2'd1, 0, 0, 0, 16'h0000, 12'h000);
    step(1, 2'd2, 0, 1, 1, 16'h9E61, 12'h000);

    // R1: reset from a non-zero state
    @(negedge clk);
    doReset();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule